// File: doc/BRIEF.md
# Programmable CRT Display Timing Generator

This block produces the raster timing for a CRT-style display from a single pixel clock. A horizontal counter runs across each line and a vertical counter steps once per line. Comparing both counts against programmed boundaries yields an active-video strobe, a blank strobe, and horizontal and vertical sync pulses.

Software programs the block through a synchronous word-wide register port. Each timing register holds two boundaries: one in the low half and one in the high half, each stored as its value minus one. A key register guards every other register against stray writes. A configuration register holds the run bit, the update-mode bit, the two sync polarities and a five-level power mode. The power mode can suppress each sync and force the blank strobe on its own.

Timing changes take effect in one of two ways. They can be applied at once, or held back and loaded only when the frame wraps, so the frame that is being scanned is never torn.

Top module: `crt_timing_gen`

## Requirements
- R1: Register word addresses are 0 key, 1 horizontal active/total, 2 horizontal blank, 3 horizontal sync, 4 vertical active/total, 5 vertical blank, 6 vertical sync, 7 configuration. A timing word stores its first value minus one in bits [15:0] and its second value minus one in bits [31:16]. For active/total the first value is the active width and the second is the total; for the blank and sync words they are the start and the end. Reading a timing word returns exactly what was last accepted.
- R2: After reset the block is locked. Writing the key 0xC0DE5A17 to address 0 unlocks it, and writing any other value (zero included) locks it. A read of address 0 returns 1 in bit 0 while unlocked and 0 while locked. Writes to addresses 1 to 7 while locked change nothing.
- R3: With the run bit set, the horizontal count wraps after total pixels, so the hsync period is the horizontal total in clocks.
- R4: Hsync is asserted from horizontal count sync-start up to, but not including, sync-end, giving a pulse of (sync end - sync start) clocks.
- R5: The vertical count advances once per line and wraps after the vertical total. The vsync period is htotal*vtotal clocks and its width is (vsync end - vsync start) lines.
- R6: Active-video is high only while the horizontal count is below the active width and the vertical count is below the active height, which gives hact*vact clocks per frame.
- R7: In the unblanked power mode, blank is high exactly while the horizontal count lies in (blank start-1, blank end-1] or the vertical count does. With blank start equal to active and blank end equal to total, blank is the complement of active-video.
- R8: Configuration bit 2 (hsync) and bit 3 (vsync) select polarity: 1 means the pulse is high, 0 means the pulse is low and the idle level is high.
- R9: Configuration bits [6:4] select the power mode. 0 passes both syncs and the blank timing. 1 forces blank and keeps both syncs. 2 forces blank and holds vsync idle. 3 forces blank and holds hsync idle. 4 to 7 force blank and hold both syncs idle.
- R10: Configuration bit 0 runs the counters. While it is clear the counters sit at zero, active-video is low, blank is high and both syncs are at their idle level. Reset leaves it clear.
- R11: When configuration bit 1 is clear, timing writes made while running take effect only when the last pixel of the frame wraps. When it is set, they take effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| active_video | output | 1 | High inside the visible region |
| blank | output | 1 | High while the DAC must be blanked |
| hsync | output | 1 | Horizontal sync, programmed polarity |
| vsync | output | 1 | Vertical sync, programmed polarity |

## Verification
The assertions assume that reset is held for at least one clock before it releases. They also assume software programs each axis with active <= blank start <= sync start <= sync end <= blank end = total, all of them within the counter width. A total lowered under immediate update may leave the counter above the new total for one clock, and the wrap property tolerates that. The bench writes only ordered timing sets, and it changes totals only upward or back to a value already used. It places its measurements on sync edges, so the fixed output register delay does not affect any interval it checks.

// File: rtl/crt_tg_pkg.sv
// Package: shared types and register addresses for the CRT timing generator.
// Assumes a word-addressed register port of eight locations.
package crt_tg_pkg;

    typedef enum logic [2:0] {
        PWR_ON    = 3'd0,
        PWR_BLANK = 3'd1,
        PWR_VSUSP = 3'd2,
        PWR_HSUSP = 3'd3,
        PWR_OFF   = 3'd4
    } pwr_mode_e;

    // Configuration word, LSB first: run, update-now, hpol, vpol, power mode.
    typedef struct packed {
        logic [2:0] pwr;
        logic       vpol;
        logic       hpol;
        logic       upd_now;
        logic       tg_en;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    localparam logic [2:0] A_KEY  = 3'd0;
    localparam logic [2:0] A_CFG  = 3'd7;

    // Index of each timing word inside the shadow arrays (address = index + 1).
    localparam int T_HACT = 0;
    localparam int T_HBLK = 1;
    localparam int T_HSYN = 2;
    localparam int T_VACT = 3;
    localparam int T_VBLK = 4;
    localparam int T_VSYN = 5;
    localparam int N_TREG = 6;

endpackage

// File: rtl/crt_tg_regs.sv
// Register file: key-guarded shadow timing words, configuration,
// and working copies loaded at once or at frame wrap.
// Assumes TW <= DW/2 and that reg_addr is stable while reg_rdata is used.
module crt_tg_regs
    import crt_tg_pkg::*;
#(
    parameter int          DW  = 32,
    parameter int          AW  = 3,
    parameter int          TW  = 12,
    parameter logic [31:0] KEY = 32'hC0DE_5A17
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata,
    input  logic                     frame_end,
    output cfg_t                     cfg,
    output logic [N_TREG-1:0][TW-1:0] work_lo,
    output logic [N_TREG-1:0][TW-1:0] work_hi
);
    localparam int HALF = DW / 2;

    logic                      unlocked;
    logic [N_TREG-1:0][TW-1:0] sh_lo;
    logic [N_TREG-1:0][TW-1:0] sh_hi;
    logic                      load_work;

    // Key register: only the exact key opens the guarded registers.
    always_ff @(posedge clk) begin
        if (!rst_n)
            unlocked <= 1'b0;
        else if (we && addr == AW'(A_KEY))
            unlocked <= (wdata == DW'(KEY));
    end

    // Shadow timing words, written only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_lo <= '0;
            sh_hi <= '0;
        end else if (we && unlocked) begin
            for (int i = 0; i < N_TREG; i++) begin
                if (addr == AW'(i + 1)) begin
                    sh_lo[i] <= wdata[TW-1:0];
                    sh_hi[i] <= wdata[HALF +: TW];
                end
            end
        end
    end

    // Configuration word, written only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (we && unlocked && addr == AW'(A_CFG))
            cfg <= cfg_t'(wdata[CFG_W-1:0]);
    end

    // Working copies follow the shadows when stopped, in immediate mode, or at frame wrap.
    assign load_work = !cfg.tg_en || cfg.upd_now || frame_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_lo <= '0;
            work_hi <= '0;
        end else if (load_work) begin
            work_lo <= sh_lo;
            work_hi <= sh_hi;
        end
    end

    // Read mux: key lock state, timing shadows, configuration.
    always_comb begin
        rdata = '0;
        if (addr == AW'(A_KEY)) begin
            rdata[0] = unlocked;
        end else if (addr == AW'(A_CFG)) begin
            rdata[CFG_W-1:0] = cfg;
        end else begin
            for (int i = 0; i < N_TREG; i++) begin
                if (addr == AW'(i + 1)) begin
                    rdata[0 +: TW]    = sh_lo[i];
                    rdata[HALF +: TW] = sh_hi[i];
                end
            end
        end
    end

    // R2: a guarded write while locked leaves every guarded register untouched.
    p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !unlocked && addr != AW'(A_KEY)) |=>
            ($stable(sh_lo) && $stable(sh_hi) && $stable(cfg)));

    // R11: in deferred mode the working timing only moves at frame wrap.
    p_defer_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.tg_en && !cfg.upd_now && !frame_end) |=>
            ($stable(work_lo) && $stable(work_hi)));

endmodule

// File: rtl/crt_tg_axis.sv
// One raster axis: a wrapping counter plus active, blank and sync window decode.
// Assumes boundaries are given as value-minus-one, as stored in the registers.
module crt_tg_axis #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic [TW-1:0] act_m1,
    input  logic [TW-1:0] tot_m1,
    input  logic [TW-1:0] bs_m1,
    input  logic [TW-1:0] be_m1,
    input  logic [TW-1:0] ss_m1,
    input  logic [TW-1:0] se_m1,
    output logic          last,
    output logic          in_act,
    output logic          in_blk,
    output logic          in_syn
);
    logic [TW-1:0] cnt;

    assign last = (cnt >= tot_m1);

    // Position counter: held at zero when stopped, wraps after the total.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (step)
            cnt <= last ? '0 : cnt + TW'(1);
    end

    // Window decode against the programmed boundaries.
    always_comb begin
        in_act = (cnt <= act_m1);
        in_blk = (cnt > bs_m1) && (cnt <= be_m1);
        in_syn = (cnt > ss_m1) && (cnt <= se_m1);
    end

    // R3: a step at or past the total returns the counter to zero.
    p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && last) |=> (cnt == '0));

    // R10: a stopped axis sits at zero.
    p_stopped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

endmodule

// File: rtl/crt_tg_out.sv
// Output stage: applies power-mode gating and polarity, registers all strobes.
// Assumes the window inputs come from the two axis decoders of the same clock.
module crt_tg_out
    import crt_tg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  logic      hpol,
    input  logic      vpol,
    input  pwr_mode_e pwr,
    input  logic      h_act,
    input  logic      v_act,
    input  logic      h_blk,
    input  logic      v_blk,
    input  logic      h_syn,
    input  logic      v_syn,
    output logic      active_o,
    output logic      blank_o,
    output logic      hsync_o,
    output logic      vsync_o
);
    logic dac_ok;
    logic hs_ok;
    logic vs_ok;

    // Power-mode decode into the three independent gates.
    always_comb begin
        unique case (pwr)
            PWR_ON:    {dac_ok, hs_ok, vs_ok} = 3'b111;
            PWR_BLANK: {dac_ok, hs_ok, vs_ok} = 3'b011;
            PWR_VSUSP: {dac_ok, hs_ok, vs_ok} = 3'b010;
            PWR_HSUSP: {dac_ok, hs_ok, vs_ok} = 3'b001;
            default:   {dac_ok, hs_ok, vs_ok} = 3'b000;
        endcase
    end

    // Registered strobes; syncs idle at the inverse of their polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            blank_o  <= 1'b1;
            hsync_o  <= 1'b1;
            vsync_o  <= 1'b1;
        end else begin
            active_o <= run && h_act && v_act;
            blank_o  <= !run || !dac_ok || h_blk || v_blk;
            hsync_o  <= (run && hs_ok && h_syn) ? hpol : !hpol;
            vsync_o  <= (run && vs_ok && v_syn) ? vpol : !vpol;
        end
    end

    // R9: any mode other than unblanked forces blank.
    p_blank_forced_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr != PWR_ON) |=> blank_o);

    // R9: hsync-suspend and power-down hold hsync idle.
    p_hs_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr == PWR_HSUSP || pwr == PWR_OFF) |=> (hsync_o == !$past(hpol)));

    // R9: vsync-suspend and power-down hold vsync idle.
    p_vs_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr == PWR_VSUSP || pwr == PWR_OFF) |=> (vsync_o == !$past(vpol)));

    // R10: stopped generator shows idle syncs, no video, blank on.
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!active_o && blank_o && hsync_o == !$past(hpol)
                  && vsync_o == !$past(vpol)));

endmodule

// File: rtl/crt_timing_gen.sv
// Top: register file, horizontal and vertical axes, output stage.
// Assumes one pixel clock for both the register port and the raster.
module crt_timing_gen
    import crt_tg_pkg::*;
#(
    parameter int          DW  = 32,
    parameter int          AW  = 3,
    parameter int          TW  = 12,
    parameter logic [31:0] KEY = 32'hC0DE_5A17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          active_video,
    output logic          blank,
    output logic          hsync,
    output logic          vsync
);
    localparam int N_AX = 2;

    cfg_t                      cfg;
    logic [N_TREG-1:0][TW-1:0] work_lo;
    logic [N_TREG-1:0][TW-1:0] work_hi;
    logic                      run;
    logic                      frame_end;
    logic [N_AX-1:0]           ax_step;
    logic [N_AX-1:0]           ax_last;
    logic [N_AX-1:0]           ax_act;
    logic [N_AX-1:0]           ax_blk;
    logic [N_AX-1:0]           ax_syn;

    crt_tg_regs #(.DW(DW), .AW(AW), .TW(TW), .KEY(KEY)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .frame_end (frame_end),
        .cfg       (cfg),
        .work_lo   (work_lo),
        .work_hi   (work_hi)
    );

    // Stepping chain: pixels every clock, lines on horizontal wrap.
    assign run        = cfg.tg_en;
    assign ax_step[0] = run;
    assign ax_step[1] = run && ax_last[0];
    assign frame_end  = run && ax_last[0] && ax_last[1];

    for (genvar a = 0; a < N_AX; a++) begin : g_axis
        localparam int B = a * 3;
        crt_tg_axis #(.TW(TW)) axis_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run),
            .step   (ax_step[a]),
            .act_m1 (work_lo[B]),
            .tot_m1 (work_hi[B]),
            .bs_m1  (work_lo[B+1]),
            .be_m1  (work_hi[B+1]),
            .ss_m1  (work_lo[B+2]),
            .se_m1  (work_hi[B+2]),
            .last   (ax_last[a]),
            .in_act (ax_act[a]),
            .in_blk (ax_blk[a]),
            .in_syn (ax_syn[a])
        );
    end

    crt_tg_out out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .hpol     (cfg.hpol),
        .vpol     (cfg.vpol),
        .pwr      (pwr_mode_e'(cfg.pwr)),
        .h_act    (ax_act[0]),
        .v_act    (ax_act[1]),
        .h_blk    (ax_blk[0]),
        .v_blk    (ax_blk[1]),
        .h_syn    (ax_syn[0]),
        .v_syn    (ax_syn[1]),
        .active_o (active_video),
        .blank_o  (blank),
        .hsync_o  (hsync),
        .vsync_o  (vsync)
    );

endmodule

// File: tb/crt_timing_gen_tb.sv
// Directed bench: one task per scenario, intervals measured between sync edges.
module crt_timing_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        active_video, blank, hsync, vsync;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    localparam logic [31:0] KEY = 32'hC0DE_5A17;
    // Timing: H active 8, front 2, sync 3, back 3 -> total 16; V 4/1/2/1 -> 8.
    localparam logic [31:0] HACT16 = {16'd15, 16'd7};
    localparam logic [31:0] HBLK16 = {16'd15, 16'd7};
    localparam logic [31:0] HSYN   = {16'd12, 16'd9};
    localparam logic [31:0] VACT   = {16'd7, 16'd3};
    localparam logic [31:0] VBLK   = {16'd7, 16'd3};
    localparam logic [31:0] VSYN   = {16'd6, 16'd4};
    localparam logic [31:0] CFG_RUN = 32'h0D; // run, deferred, both pulses high, unblanked

    always #2 clk = ~clk; // 250 MHz

    crt_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .active_video(active_video),
        .blank(blank), .hsync(hsync), .vsync(vsync)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic bit sig(input int which);
        return (which == 0) ? hsync : vsync;
    endfunction

    // Wait for the signal to enter its asserted level; returns 0 on timeout.
    task automatic wait_rise(input int which, input bit pol, output bit ok);
        bit prev;
        ok = 1'b0;
        @(negedge clk);
        prev = sig(which);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (prev != pol && sig(which) == pol) begin
                ok = 1'b1;
                break;
            end
            prev = sig(which);
        end
    endtask

    task automatic period(input int which, input bit pol, output int gap);
        bit ok;
        bit prev;
        gap = -1;
        wait_rise(which, pol, ok);
        if (!ok) return;
        prev = pol;
        for (int i = 1; i < 2000; i++) begin
            @(negedge clk);
            if (prev != pol && sig(which) == pol) begin
                gap = i;
                break;
            end
            prev = sig(which);
        end
    endtask

    task automatic width(input int which, input bit pol, output int w);
        bit ok;
        w = -1;
        wait_rise(which, pol, ok);
        if (!ok) return;
        w = 1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (sig(which) != pol) break;
            w++;
        end
    endtask

    task automatic window(input int n, output int act_c, output int blk_c, output int mism,
                          output int hs_t, output int vs_t);
        bit ph, pv;
        act_c = 0; blk_c = 0; mism = 0; hs_t = 0; vs_t = 0;
        @(negedge clk);
        ph = hsync; pv = vsync;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            act_c += int'(active_video);
            blk_c += int'(blank);
            mism  += int'(blank == active_video);
            hs_t  += int'(hsync != ph);
            vs_t  += int'(vsync != pv);
            ph = hsync; pv = vsync;
        end
    endtask

    task automatic program_std();
        wr(3'd0, KEY);
        wr(3'd7, 32'h0);
        wr(3'd1, HACT16); wr(3'd2, HBLK16); wr(3'd3, HSYN);
        wr(3'd4, VACT);   wr(3'd5, VBLK);   wr(3'd6, VSYN);
        wr(3'd7, CFG_RUN);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        chk(hsync == 1'b1 && vsync == 1'b1, "R10 reset sync idle", {hsync, vsync}, 3);
        chk(active_video == 1'b0 && blank == 1'b1, "R10 reset video off", {active_video, blank}, 1);
        rd(3'd0, d);
        chk(d == 32'd0, "R2 reset locked", d, 0);
        rd(3'd1, d);
        chk(d == 32'd0, "R1 reset timing zero", d, 0);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        wr(3'd1, 32'h0123_0456);
        wr(3'd7, 32'h0D);
        rd(3'd1, d);
        chk(d == 32'd0, "R2 locked write ignored", d, 0);
        rd(3'd7, d);
        chk(d == 32'd0, "R2 locked cfg ignored", d, 0);
        wr(3'd0, KEY);
        rd(3'd0, d);
        chk(d == 32'd1, "R2 key unlocks", d, 1);
        wr(3'd6, 32'h0321_0654);
        rd(3'd6, d);
        chk(d == 32'h0321_0654, "R1 field readback", d, 32'h0321_0654);
        wr(3'd0, 32'd0);
        rd(3'd0, d);
        chk(d == 32'd0, "R2 zero locks", d, 0);
        wr(3'd6, 32'h0111_0222);
        rd(3'd6, d);
        chk(d == 32'h0321_0654, "R2 relocked write ignored", d, 32'h0321_0654);
    endtask

    task automatic t_raster();
        int g, a, b, m, h, v;
        program_std();
        repeat (200) @(negedge clk);
        period(0, 1'b1, g);
        chk(g == 16, "R3 hsync period", g, 16);
        width(0, 1'b1, g);
        chk(g == 3, "R4 hsync width", g, 3);
        period(1, 1'b1, g);
        chk(g == 128, "R5 vsync period", g, 128);
        width(1, 1'b1, g);
        chk(g == 32, "R5 vsync width", g, 32);
        window(128, a, b, m, h, v);
        chk(a == 32, "R6 active per frame", a, 32);
        chk(b == 96, "R7 blank per frame", b, 96);
        chk(m == 0, "R7 blank complements active", m, 0);
    endtask

    task automatic t_polarity();
        int w, a, b, m, h, v;
        wr(3'd7, 32'h01);
        repeat (150) @(negedge clk);
        width(0, 1'b0, w);
        chk(w == 3, "R8 hsync low pulse", w, 3);
        width(1, 1'b0, w);
        chk(w == 32, "R8 vsync low pulse", w, 32);
        wr(3'd7, 32'h10 | 32'h01);
        repeat (4) @(negedge clk);
        window(128, a, b, m, h, v);
        chk(b == 128, "R9 blank forced (low pol)", b, 128);
        chk(h > 0 && v > 0, "R9 mode 1 syncs kept (low pol)", h + v, 1);
        wr(3'd7, CFG_RUN);
    endtask

    task automatic t_power();
        int a, b, m, h, v;
        for (int md = 0; md < 5; md++) begin
            bit hs_exp = (md == 0 || md == 1 || md == 2);
            bit vs_exp = (md == 0 || md == 1 || md == 3);
            wr(3'd7, CFG_RUN | (32'(md) << 4));
            repeat (4) @(negedge clk);
            window(128, a, b, m, h, v);
            chk((h > 0) == hs_exp, $sformatf("R9 mode %0d hsync", md), h, int'(hs_exp));
            chk((v > 0) == vs_exp, $sformatf("R9 mode %0d vsync", md), v, int'(vs_exp));
            chk(b == ((md == 0) ? 96 : 128), $sformatf("R9 mode %0d blank", md), b,
                (md == 0) ? 96 : 128);
            if (!hs_exp) chk(hsync == 1'b0, "R9 hsync idle level", hsync, 0);
        end
        wr(3'd7, CFG_RUN);
    endtask

    task automatic t_stop();
        int a, b, m, h, v;
        wr(3'd7, 32'h0C);
        repeat (2) @(negedge clk);
        window(64, a, b, m, h, v);
        chk(a == 0 && b == 64, "R10 stopped video", a + b, 64);
        chk(h == 0 && v == 0 && hsync == 1'b0 && vsync == 1'b0, "R10 stopped syncs idle",
            h + v + int'(hsync) + int'(vsync), 0);
        wr(3'd7, CFG_RUN);
        repeat (40) @(negedge clk);
        period(0, 1'b1, h);
        chk(h == 16, "R10 restart hsync period", h, 16);
    endtask

    task automatic t_update();
        int g;
        bit ok;
        // Deferred: change total mid-frame, old period holds until the wrap.
        wait_rise(1, 1'b1, ok);
        wr(3'd1, {16'd19, 16'd7});
        period(0, 1'b1, g);
        chk(g == 16, "R11 deferred keeps old total", g, 16);
        wait_rise(1, 1'b1, ok);
        period(0, 1'b1, g);
        chk(g == 20, "R11 new total after wrap", g, 20);
        // Immediate mode.
        wr(3'd7, CFG_RUN | 32'h2);
        wait_rise(1, 1'b1, ok);
        wr(3'd1, {16'd23, 16'd7});
        period(0, 1'b1, g);
        chk(g == 24, "R11 immediate total", g, 24);
        wr(3'd7, CFG_RUN);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lock();
        t_raster();
        t_polarity();
        t_power();
        t_stop();
        t_update();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule